// File: doc/BRIEF.md
# Eight-Step Complex Phase Rotator

This block turns a signed complex sample (I, Q) through one of eight angles spaced 45 degrees apart. It is meant for a digital mixer whose local oscillator only ever needs those eight phases. No general multiplier is used. Rotations by multiples of 90 degrees are formed by exchanging the two component buses and taking the two's complement of one or both of them. The odd multiples of 45 degrees first scale the sum and the difference of the components by a fixed constant, which is built from shifts and adds. They then pass through the same exchange-and-negate stage.

The 3-bit phase code is interpreted as follows. Bit 0 adds 45 degrees. Bits [2:1] pick the quadrant: 0, 90, 180 or 270 degrees. Rotation is counter-clockwise, so that out_i = I·cos θ − Q·sin θ and out_q = I·sin θ + Q·cos θ, with θ = code × 45°. A sample presented with its strobe leaves the block exactly two clocks later. Its flag travels alongside it.

Top module: `quad_phase_rotator`

## Requirements
- R1: While rst_n is low, and on the first sampling after reset is released, out_valid, out_i and out_q are all 0.
- R2: out_valid equals the in_valid that was applied two rising clock edges earlier, and out_i/out_q belong to that same sample.
- R3: Phase code 0 passes the sample through unchanged: out_i = I and out_q = Q.
- R4: Codes 2, 4 and 6 (90, 180 and 270 degrees) are exact. Code 2 gives (−Q, I), code 4 gives (−I, −Q) and code 6 gives (Q, −I).
- R5: Code 1 (45 degrees) gives out_i = K·(I − Q) and out_q = K·(I + Q), where K = 46341/65536. Each result is within 1 LSB of the exactly rounded value of the true rotation.
- R6: Codes 3, 5 and 7 (135, 225 and 315 degrees) equal the 45-degree result followed by the quadrant step of R4. Each is within 1 LSB of the rounded true rotation.
- R7: Every output saturates to the 16-bit signed range. Negating −32768 yields 32767, and 45-degree results beyond the range clip to 32767 or −32768.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | Input in-phase component, two's complement |
| in_q | input | 16 | Input quadrature component, two's complement |
| phase | input | 3 | Rotation code, steps of 45 degrees |
| out_valid | output | 1 | Output sample flag |
| out_i | output | 16 | Rotated in-phase component, saturated |
| out_q | output | 16 | Rotated quadrature component, saturated |

## Verification
Suppose the quadrant field held in the middle register is wrong. Then the sample that follows comes out two clocks later with its components swapped or with the wrong sign. For the even codes this shows up as an exact mismatch. Suppose instead the scaling sum loses a partial product or rounds the wrong way. Then the error appears only on the odd codes, and the deviation grows with the input magnitude. Large full-scale inputs therefore expose such a fault at once. A broken strobe delay shows as out_valid one clock early or late against the model's two-clock queue.

// File: rtl/qrot_pkg.sv
package qrot_pkg;

    // Quadrant selector taken from phase code bits [2:1]
    typedef enum logic [1:0] {
        QUAD_0   = 2'd0,
        QUAD_90  = 2'd1,
        QUAD_180 = 2'd2,
        QUAD_270 = 2'd3
    } quad_e;

endpackage

// File: rtl/qrot_const_scale.sv
// Multiplies a signed value by a fixed fraction COEF / 2**FRAC using
// shift-add partial products, rounding half up to nearest.
module qrot_const_scale #(
    parameter int              SW   = 17,
    parameter int              FRAC = 16,
    parameter logic [FRAC-1:0] COEF = 16'hB505
) (
    input  logic signed [SW-1:0] x,
    output logic signed [SW-1:0] y
);
    localparam int PW = SW + FRAC;
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);

    logic signed [PW-1:0] xe;
    logic signed [PW-1:0] pp [FRAC];
    logic signed [PW-1:0] acc;

    assign xe = PW'(x);

    for (genvar k = 0; k < FRAC; k++) begin : g_pp
        if (COEF[k]) begin : g_on
            assign pp[k] = xe <<< k;
        end else begin : g_off
            assign pp[k] = '0;
        end
    end

    always_comb begin
        acc = HALF;
        for (int k = 0; k < FRAC; k++) begin
            acc = acc + pp[k];
        end
    end

    assign y = SW'(acc >>> FRAC);

endmodule

// File: rtl/qrot_quadrant.sv
// Exchanges and negates the two components by quadrant, then clips to DW bits.
module qrot_quadrant import qrot_pkg::*; #(
    parameter int DW = 16
) (
    input  quad_e                quad,
    input  logic signed [DW:0]   a,
    input  logic signed [DW:0]   b,
    output logic signed [DW-1:0] oi,
    output logic signed [DW-1:0] oq
);
    localparam int SW = DW + 1;

    function automatic logic signed [DW-1:0] clip(input logic signed [SW-1:0] v);
        if (v > $signed({2'b00, {(DW-1){1'b1}}}))
            return {1'b0, {(DW-1){1'b1}}};
        else if (v < $signed({2'b11, {(DW-1){1'b0}}}))
            return {1'b1, {(DW-1){1'b0}}};
        else
            return v[DW-1:0];
    endfunction

    logic signed [SW-1:0] ri, rq;

    always_comb begin
        unique case (quad)
            QUAD_0:   begin ri = a;  rq = b;  end
            QUAD_90:  begin ri = -b; rq = a;  end
            QUAD_180: begin ri = -a; rq = -b; end
            default:  begin ri = b;  rq = -a; end
        endcase
        oi = clip(ri);
        oq = clip(rq);
    end

endmodule

// File: rtl/quad_phase_rotator.sv
module quad_phase_rotator import qrot_pkg::*; #(
    parameter int              DW   = 16,
    parameter int              FRAC = 16,
    parameter logic [FRAC-1:0] COEF = 16'hB505
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    input  logic [2:0]           phase,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_i,
    output logic signed [DW-1:0] out_q
);
    localparam int SW = DW + 1;

    typedef struct packed {
        logic                 vld;
        quad_e                quad;
        logic signed [SW-1:0] a;
        logic signed [SW-1:0] b;
    } stg1_t;

    typedef struct packed {
        logic                 vld;
        logic signed [DW-1:0] i;
        logic signed [DW-1:0] q;
    } stg2_t;

    stg1_t s1_d, s1_q;
    stg2_t s2_d, s2_q;

    logic signed [SW-1:0] diff_w, sum_w, diff_k, sum_k;
    logic signed [DW-1:0] rot_i, rot_q;

    assign diff_w = SW'(in_i) - SW'(in_q);
    assign sum_w  = SW'(in_i) + SW'(in_q);

    qrot_const_scale #(.SW(SW), .FRAC(FRAC), .COEF(COEF)) u_scale_re (
        .x (diff_w),
        .y (diff_k)
    );

    qrot_const_scale #(.SW(SW), .FRAC(FRAC), .COEF(COEF)) u_scale_im (
        .x (sum_w),
        .y (sum_k)
    );

    qrot_quadrant #(.DW(DW)) u_quad (
        .quad (s1_q.quad),
        .a    (s1_q.a),
        .b    (s1_q.b),
        .oi   (rot_i),
        .oq   (rot_q)
    );

    always_comb begin
        s1_d.vld  = in_valid;
        s1_d.quad = quad_e'(phase[2:1]);
        if (phase[0]) begin
            s1_d.a = diff_k;
            s1_d.b = sum_k;
        end else begin
            s1_d.a = SW'(in_i);
            s1_d.b = SW'(in_q);
        end

        s2_d.vld = s1_q.vld;
        s2_d.i   = rot_i;
        s2_d.q   = rot_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_valid = s2_q.vld;
    assign out_i     = s2_q.i;
    assign out_q     = s2_q.q;

endmodule

// File: rtl/quad_phase_rotator_chk.sv
module quad_phase_rotator_chk #(
    parameter int DW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic signed [DW-1:0] in_i,
    input logic signed [DW-1:0] in_q,
    input logic [2:0]           phase,
    input logic                 out_valid,
    input logic signed [DW-1:0] out_i,
    input logic signed [DW-1:0] out_q
);
    localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};

    // R2: strobe travels with a fixed two-clock delay
    a_r2_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);
    a_r2_valid_clr: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R3: code 0 passes the sample through
    a_r3_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && phase == 3'd0) |-> ##2
        (out_i == $past(in_i, 2) && out_q == $past(in_q, 2)));

    // R4: 90 degrees moves I onto Q
    a_r4_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && phase == 3'd2) |-> ##2 (out_q == $past(in_i, 2)));

    // R4: 180 degrees negates I when no clipping is needed
    a_r4_negate: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && phase == 3'd4 && in_i != MINV) |-> ##2
        (out_i == -$past(in_i, 2)));

    // R7: negating the most negative value gives the most positive value
    a_r7_sat_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && phase == 3'd4 && in_i == MINV) |-> ##2 (out_i == MAXV));

endmodule

bind quad_phase_rotator quad_phase_rotator_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_i      (in_i),
    .in_q      (in_q),
    .phase     (phase),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
);

// File: tb/quad_phase_rotator_bench.sv
`timescale 1ns/1ps
module quad_phase_rotator_bench;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_i = '0;
    logic signed [15:0] in_q = '0;
    logic [2:0]         phase = '0;
    logic               out_valid;
    logic signed [15:0] out_i, out_q;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        bit    v;
        int    ei;
        int    eq;
        int    tol;
        string tag;
    } exp_t;

    exp_t pipe[$];

    always #4 clk = ~clk;

    quad_phase_rotator u_quad_phase_rotator (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_i      (in_i),
        .in_q      (in_q),
        .phase     (phase),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );

    function automatic int clip16(int v, output bit clipped);
        clipped = 1'b0;
        if (v > 32767)  begin clipped = 1'b1; return 32767;  end
        if (v < -32768) begin clipped = 1'b1; return -32768; end
        return v;
    endfunction

    function automatic int rnd(real v);
        return int'($floor(v + 0.5));
    endfunction

    task automatic check_val(string tag, string what, int act, int exp, int tol);
        int d;
        checks++;
        d = act - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model(bit v, int xi, int xq, int code);
        exp_t e;
        real  th, ri, rq;
        bit   ci, cq;
        th = code * 3.14159265358979 / 4.0;
        ri = xi * $cos(th) - xq * $sin(th);
        rq = xi * $sin(th) + xq * $cos(th);
        e.v   = v;
        e.ei  = clip16(rnd(ri), ci);
        e.eq  = clip16(rnd(rq), cq);
        e.tol = code[0] ? 1 : 0;
        if (ci || cq)        e.tag = "R7";
        else if (code == 0)  e.tag = "R3";
        else if (code == 1)  e.tag = "R5";
        else if (code[0])    e.tag = "R6";
        else                 e.tag = "R4";
        return e;
    endfunction

    // Called at a falling edge: compare the sample driven two falling edges ago,
    // then drive the next sample.
    task automatic step(bit v, int xi, int xq, int code);
        @(negedge clk);
        if (pipe.size() == 2) begin
            exp_t e;
            e = pipe.pop_front();
            check_val("R2", "out_valid", int'(out_valid), int'(e.v), 0);
            if (e.v) begin
                check_val(e.tag, "out_i", int'(out_i), e.ei, e.tol);
                check_val(e.tag, "out_q", int'(out_q), e.eq, e.tol);
            end
        end
        in_valid = v;
        in_i     = 16'(xi);
        in_q     = 16'(xq);
        phase    = 3'(code);
        pipe.push_back(model(v, int'(in_i), int'(in_q), code));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int vals[8];
        vals = '{0, 1, -1, 32767, -32768, 12345, -20000, 23170};

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_val("R1", "out_valid in reset", int'(out_valid), 0, 0);
        check_val("R1", "out_i in reset", int'(out_i), 0, 0);
        check_val("R1", "out_q in reset", int'(out_q), 0, 0);
        in_valid = 1'b1;
        rst_n    = 1'b1;
        @(negedge clk);
        check_val("R1", "out_valid after reset", int'(out_valid), 0, 0);
        check_val("R1", "out_q after reset", int'(out_q), 0, 0);
        in_valid = 1'b0;

        // Directed: every code against every pair of corner values
        for (int c = 0; c < 8; c++) begin
            for (int a = 0; a < 8; a++) begin
                for (int b = 0; b < 8; b++) begin
                    step(1'b1, vals[a], vals[b], c);
                end
            end
        end

        // Strobe gaps and back-to-back codes (R2)
        for (int n = 0; n < 40; n++) begin
            step(n % 3 == 0, 1000 * n - 20000, 15000 - 700 * n, n % 8);
        end

        // Pseudo-random samples and strobes
        for (int n = 0; n < 3000; n++) begin
            step($urandom_range(0, 3) != 0, int'($signed(16'($urandom))),
                 int'($signed(16'($urandom))), int'($urandom_range(0, 7)));
        end

        // Drain the pipeline
        step(1'b0, 0, 0, 0);
        step(1'b0, 0, 0, 0);
        step(1'b0, 0, 0, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule